// File: doc/BRIEF.md
# Power-of-two clock divider bank with enable

The block holds a row of identical divider channels. All of them run from one reference clock. Each channel emits a one-cycle strobe at the reference rate divided by a power of two. A 3-bit code selects the ratio 2^(code-1), and code 0 acts as code 1. Software reaches each channel through a small synchronous register port. Each channel has a window of 0x100 addresses, and channel k starts at k × 0x100. Each window holds a divide-control register and an enable-control register.

A set enable bit passes through a two-stage synchronizer before it starts the channel's counter. Starting and stopping happen only on whole output periods, so no period is ever cut short. The channel loads the ratio at the moment it starts. A code written while the channel runs is stored and read back, but takes effect only after the next stop and start. The enable register also shows a read-only running flag, so software can see when a stop has completed.

Top module: `clkdiv_bank`

## Requirements
- R1: After reset, every channel reads divide code 0, enable 0 and running 0, and no strobe is produced.
- R2: Channel k decodes addresses k×0x100 + offset. Offset 0x43 holds the divide code in bits [2:0], and its other bits read 0. Offset 0x46 holds the read/write enable in bit 7 and a read-only running flag in bit 0, and its other bits read 0.
- R3: While running, tick_o pulses for one cycle every ratio cycles, where ratio = 2^(code-1) for codes 1..7 and ratio = 1 for code 0. No strobe appears unless run_o is high.
- R4: The first strobe appears in the third clock cycle after the write edge that sets the enable bit, which is well inside the limit of 2 + 3×ratio cycles.
- R5: After the write edge that clears the enable bit, run_o falls within 3×ratio cycles.
- R6: Stopping completes the current period: run_o falls exactly ratio cycles after the last strobe, and no strobe follows.
- R7: A divide code written while running reads back at once, but the strobe period keeps the old ratio until the channel is disabled and enabled again. The new ratio then applies from the first period.
- R8: Channels are independent. Writes to one channel change no other channel's registers or strobes.
- R9: Reads of unmapped offsets, or of channel indices at or above NUM_INST, return 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data, combinational on reg_addr_i |
| tick_o | output | NUM_INST | Per-channel divided strobe |
| run_o | output | NUM_INST | Per-channel running flag |

## Verification
Assertions check four things on every cycle: that no strobe appears outside the running state, that the latched ratio does not change during a run, that a run ends only on the last count of a period, and that the start and stop windows stay inside their bounds. Counters track those windows. Assertions also check that a write to an unmapped address leaves all registers unchanged. Only the bench scenarios can show the exact strobe spacing for each code, the three-cycle start latency, the register readback values, and that a code written mid-run is deferred. Independence between channels running at different ratios is also shown only by the scenarios.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int unsigned CODE_W   = 3;
  localparam int unsigned WIN_LSB  = 8;
  localparam logic [7:0]  OFS_DIV  = 8'h43;
  localparam logic [7:0]  OFS_EN   = 8'h46;
  localparam int unsigned EN_BIT   = 7;
  localparam int unsigned RUN_BIT  = 0;

  typedef enum logic {ST_IDLE, ST_RUN} run_st_e;

  // code 0 aliases code 1 (divide by one)
  function automatic logic [CODE_W-1:0] code_to_shift(input logic [CODE_W-1:0] code);
    return (code == '0) ? '0 : code - 1'b1;
  endfunction
endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
  import clkdiv_pkg::*;
#(
  parameter int unsigned NUM_INST = 2,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 8
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [DATA_W-1:0]                wdata_i,
  input  logic [NUM_INST-1:0]              run_i,
  output logic [DATA_W-1:0]                rdata_o,
  output logic [NUM_INST-1:0]              en_o,
  output logic [NUM_INST-1:0][CODE_W-1:0]  code_o
);
  localparam int unsigned SEL_W = ADDR_W - WIN_LSB;

  logic [SEL_W-1:0] sel;
  logic [7:0]       ofs;
  logic             inst_ok;
  logic [NUM_INST-1:0]             en_q;
  logic [NUM_INST-1:0][CODE_W-1:0] code_q;

  assign sel     = addr_i[ADDR_W-1:WIN_LSB];
  assign ofs     = addr_i[WIN_LSB-1:0];
  assign inst_ok = (int'(sel) < NUM_INST);

  for (genvar g = 0; g < NUM_INST; g++) begin : g_inst
    logic hit;
    assign hit = we_i && inst_ok && (sel == SEL_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q[g]   <= 1'b0;
        code_q[g] <= '0;
      end else if (hit) begin
        if (ofs == OFS_DIV) code_q[g] <= wdata_i[CODE_W-1:0];
        if (ofs == OFS_EN)  en_q[g]   <= wdata_i[EN_BIT];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NUM_INST; k++) begin
      if (inst_ok && sel == SEL_W'(k)) begin
        if (ofs == OFS_DIV) rdata_o[CODE_W-1:0] = code_q[k];
        if (ofs == OFS_EN) begin
          rdata_o[EN_BIT]  = en_q[k];
          rdata_o[RUN_BIT] = run_i[k];
        end
      end
    end
  end

  assign en_o   = en_q;
  assign code_o = code_q;

  // R9
  unmapped_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (!inst_ok || (ofs != OFS_DIV && ofs != OFS_EN))) |=>
      ($stable(en_q) && $stable(code_q)));
endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core
  import clkdiv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              tick_o,
  output logic              run_o
);
  localparam int unsigned CNT_W = (1 << CODE_W) - 2;

  logic              en_s1_q, en_s2_q;
  run_st_e           st_q;
  logic [CODE_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W:0]    one_c, span_c;
  logic              last_c;

  assign one_c  = {{CNT_W{1'b0}}, 1'b1} << sh_q;
  assign span_c = one_c - 1'b1;
  assign last_c = (cnt_q == span_c[CNT_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_s1_q <= 1'b0;
      en_s2_q <= 1'b0;
    end else begin
      en_s1_q <= en_i;
      en_s2_q <= en_s1_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (en_s2_q) begin
          st_q  <= ST_RUN;
          sh_q  <= code_to_shift(code_i);
          cnt_q <= '0;
        end
        ST_RUN: if (last_c) begin
          cnt_q <= '0;
          if (!en_s2_q) st_q <= ST_IDLE;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign run_o  = (st_q == ST_RUN);
  assign tick_o = run_o && (cnt_q == '0);

  // window counters for bound checks
  logic [7:0] on_cnt_q, off_cnt_q;
  logic [9:0] ratio_w;
  assign ratio_w = 10'(one_c);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_cnt_q  <= '0;
      off_cnt_q <= '0;
    end else begin
      on_cnt_q  <= (en_i && !run_o) ? on_cnt_q + 1'b1 : '0;
      off_cnt_q <= (!en_i && run_o) ? off_cnt_q + 1'b1 : '0;
    end
  end

  // R3
  tick_in_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> run_o);
  // R4
  start_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !run_o) |-> (on_cnt_q <= 8'd2));
  // R5
  stop_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && run_o) |-> (10'(off_cnt_q) < 10'd3 * ratio_w));
  // R6
  stop_on_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_o) |-> $past(cnt_q == span_c[CNT_W-1:0]));
  // R7
  ratio_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && $past(run_o)) |-> $stable(sh_q));
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
  import clkdiv_pkg::*;
#(
  parameter int unsigned NUM_INST = 2,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  output logic [NUM_INST-1:0] tick_o,
  output logic [NUM_INST-1:0] run_o
);
  logic [NUM_INST-1:0]             en;
  logic [NUM_INST-1:0][CODE_W-1:0] code;

  clkdiv_regs #(
    .NUM_INST (NUM_INST),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .run_i   (run_o),
    .rdata_o (reg_rdata_o),
    .en_o    (en),
    .code_o  (code)
  );

  for (genvar g = 0; g < NUM_INST; g++) begin : g_core
    clkdiv_core u_core (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en[g]),
      .code_i (code[g]),
      .tick_o (tick_o[g]),
      .run_o  (run_o[g])
    );
  end
endmodule

// File: tb/clkdiv_bank_bench.sv
module clkdiv_bank_bench;
  localparam int NUM_INST = 2;
  localparam int ADDR_W   = 12;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic reg_we_i = 1'b0;
  logic [ADDR_W-1:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic [NUM_INST-1:0] tick_o, run_o;

  int errors = 0, checks = 0, cyc = 0;
  int last_tick [NUM_INST];
  bit done = 0;

  always #10 clk_i = ~clk_i;

  clkdiv_bank #(.NUM_INST(NUM_INST), .ADDR_W(ADDR_W), .DATA_W(8)) u_clkdiv_bank (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i,
    .reg_rdata_o, .tick_o, .run_o
  );

  function automatic int ratio_of(input int code);
    return (code == 0) ? 1 : (1 << (code - 1));
  endfunction

  function automatic logic [ADDR_W-1:0] a_div(input int i);
    return ADDR_W'(i * 256 + 'h43);
  endfunction
  function automatic logic [ADDR_W-1:0] a_en(input int i);
    return ADDR_W'(i * 256 + 'h46);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
    cyc++;
    for (int i = 0; i < NUM_INST; i++) if (tick_o[i]) last_tick[i] = cyc;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    @(posedge clk_i);
    step();
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output int d);
    reg_addr_i = a;
    #1;
    d = int'(reg_rdata_o);
  endtask

  // R4: first strobe three cycles after the enabling write edge
  task automatic enable_and_check(input int i);
    wr(a_en(i), 8'h80 | 8'($urandom % 128));
    step(); check("R4 tick c1", int'(tick_o[i]), 0);
    step(); check("R4 tick c2", int'(tick_o[i]), 0);
    step(); check("R4 tick c3", int'(tick_o[i]), 1);
  endtask

  // R3: spacing between consecutive strobes
  task automatic period_check(input int i, input int exp, input string req);
    int t0, n;
    n = 0;
    while (!tick_o[i] && n < 200) begin step(); n++; end
    t0 = cyc;
    step(); n = 0;
    while (!tick_o[i] && n < 200) begin step(); n++; end
    check(req, cyc - t0, exp);
  endtask

  // R5, R6: disable and verify stop timing
  task automatic disable_and_check(input int i, input int r);
    int n, t_wr;
    wr(a_en(i), 8'($urandom % 128));
    t_wr = cyc; n = 0;
    while (run_o[i] && n < 500) begin step(); n++; end
    checks++;
    if (cyc - t_wr > 3 * r) begin
      errors++;
      $display("FAIL R5: stop latency actual=%0d expected<=%0d", cyc - t_wr, 3 * r);
    end
    check("R6 last period", cyc - last_tick[i], r);
    check("R6 no tick after stop", int'(tick_o[i]), 0);
  endtask

  initial begin
    int d, inst, code;
    d = $urandom(32'd20240611);
    for (int i = 0; i < NUM_INST; i++) last_tick[i] = 0;
    repeat (3) step();
    rst_ni = 1'b1;
    step();

    // R1 reset state
    for (int i = 0; i < NUM_INST; i++) begin
      rd(a_div(i), d); check("R1 div code", d, 0);
      rd(a_en(i), d);  check("R1 enable/run", d, 0);
    end
    check("R1 tick", int'(tick_o), 0);
    check("R1 run", int'(run_o), 0);

    // R2 readback and reserved bits
    wr(a_div(1), 8'hFD);
    rd(a_div(1), d); check("R2 div reserved bits", d, 5);
    rd(a_div(0), d); check("R8 other channel code", d, 0);
    wr(a_en(1), 8'h7F);
    rd(a_en(1), d);  check("R2 enable bit0 read-only", d, 0);

    // R9 unmapped
    rd(12'h044, d); check("R9 read unmapped offset", d, 0);
    rd(12'h243, d); check("R9 read absent channel", d, 0);
    wr(12'h044, 8'hFF);
    wr(12'h243, 8'h07);
    wr(12'h346, 8'h80);
    rd(a_div(0), d); check("R9 write ignored div0", d, 0);
    rd(a_en(0), d);  check("R9 write ignored en0", d, 0);
    rd(a_div(1), d); check("R9 write ignored div1", d, 5);
    step(); step(); step();
    check("R9 no run", int'(run_o), 0);

    // R7 deferred ratio change
    wr(a_div(0), 8'd2);
    enable_and_check(0);
    period_check(0, 2, "R3 period code2");
    wr(a_div(0), 8'd5);
    rd(a_div(0), d); check("R7 code readback mid-run", d, 5);
    period_check(0, 2, "R7 old ratio kept");
    period_check(0, 2, "R7 old ratio kept again");
    disable_and_check(0, 2);
    enable_and_check(0);
    period_check(0, 16, "R7 new ratio after re-enable");
    disable_and_check(0, 16);

    // R8 independence
    wr(a_div(0), 8'd0);
    wr(a_div(1), 8'd3);
    enable_and_check(0);
    enable_and_check(1);
    period_check(0, 1, "R8 ch0 ratio1");
    period_check(1, 4, "R8 ch1 ratio4");
    rd(a_en(1), d); check("R2 enable+run readback", d, 'h81);
    disable_and_check(0, 1);
    period_check(1, 4, "R8 ch1 unaffected");
    check("R8 ch0 stopped", int'(run_o[0]), 0);
    disable_and_check(1, 4);

    // R3 randomized ratios
    for (int it = 0; it < 24; it++) begin
      inst = $urandom % NUM_INST;
      code = (it < 8) ? it : int'($urandom % 8);
      wr(a_div(inst), 8'(code) | 8'(($urandom % 32) << 3));
      rd(a_div(inst), d); check("R2 div random", d, code);
      enable_and_check(inst);
      period_check(inst, ratio_of(code), "R3 period random");
      period_check(inst, ratio_of(code), "R3 period random 2");
      rd(a_en(inst), d); check("R2 running flag", d, 'h81);
      disable_and_check(inst, ratio_of(code));
      rd(a_en(inst), d); check("R5 stopped flag", d, 0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule